// File: doc/BRIEF.md
# Operation Cycle Sequencer with Single-Step

This control block decides when operation cycles (OP cycles) run in a digit-serial calculating machine. A number cycle is one full pass through every digit interval of the working registers. The datapath raises `num_end` on the last clock of each number cycle. An OP cycle is a number cycle during which processing takes place, and `op` is high for all of it. The block takes a one-clock key strobe that carries a class bit, simple or multi-cycle, and a completion flag from the datapath. From these it decides in which number cycles `op` is raised and when the machine leaves and returns to the idle state.

A simple key, such as entering a digit, gets exactly one OP cycle, and the machine stays idle. A multi-cycle key gets a first OP cycle, and at the end of that cycle the idle bit is cleared. OP cycles then follow one after another until the datapath reports completion at the end of an OP cycle. At that point the machine returns to idle. With the manual switch on, this automatic chaining stops: while calculating, each press of the step key gives exactly one OP cycle, so an operation can be walked through cycle by cycle. The display enable follows the idle bit, and an external force input can also turn it on.

Top module: `op_cycle_seq`

## Requirements
- R1: While `rst` is high, and on the first clock after it falls, `op` is 0, `idle` is 1 and `disp_en` is 1 (with `disp_force` low).
- R2: `op` changes only on the clock edge at which `num_end` is high, so it holds one value through each whole number cycle.
- R3: After a key strobe, its first OP cycle is the number cycle that follows the one in which the strobe arrived, including a strobe in the same clock as `num_end`.
- R4: A strobe with `key_multi` = 0 gives exactly one OP cycle and never lowers `idle`.
- R5: A strobe with `key_multi` = 1 lowers `idle` at the end of its first OP cycle. With `manual` low, `op` is then high in every number cycle until `done` is seen high at the end of an OP cycle, and `idle` returns to 1 at that edge. With `done` first seen in the k-th calculating cycle, there are 1+k OP cycles and k number cycles with `idle` low.
- R6: `done` is sampled only at the end of an OP cycle while `idle` is 0. Outside that edge it has no effect on `idle`.
- R7: With `manual` high during a calculation, no OP cycle occurs without a step. Each rising edge of `step_key` gives exactly one OP cycle, which starts within two number cycles, and a key held high counts once.
- R8: A step press while `idle` is 1 is discarded and causes no OP cycle, now or later.
- R9: `disp_en` equals `idle` OR the value `disp_force` had on the previous clock.
- R10: A key strobe that arrives while the machine is busy is held and run once the machine would otherwise be idle. Further strobes that arrive while one is held are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| num_end | input | 1 | High on the last clock of each number cycle |
| key_stb | input | 1 | One-clock key event strobe |
| key_multi | input | 1 | Class of the key event: 1 multi-cycle, 0 simple |
| done | input | 1 | Datapath reports that the operation is complete |
| manual | input | 1 | Manual single-step mode switch |
| step_key | input | 1 | Step key level, asynchronous |
| disp_force | input | 1 | External display enable override |
| op | output | 1 | OP cycle active |
| idle | output | 1 | 1 when idle, 0 while calculating |
| disp_en | output | 1 | Display enable |

## Verification
The assertions assume that `num_end` is a single-clock pulse that arrives on a fixed period of several clocks. They also assume that `key_stb` lasts one clock and that `done` is meaningful only in the last clock of an OP cycle. The bench makes `num_end` from a free-running counter of eight clocks. It sends each key strobe for exactly one clock, at an offset that is swept across the number cycle. It raises `done` from the count of calculating OP cycles it has seen, so completion lands on a chosen cycle. The step key is held across more than one number cycle to check the edge detection, and `done` is forced high while no OP cycle is running to check that it is ignored.

// File: rtl/op_seq_pkg.sv
package op_seq_pkg;
  typedef struct packed {
    logic valid;
    logic multi;
  } key_req_t;
endpackage

// File: rtl/key_hold.sv
module key_hold
  import op_seq_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     key_stb,
  input  logic     key_multi,
  input  logic     take,
  output key_req_t req
);
  key_req_t held;

  always_ff @(posedge clk) begin
    if (rst) begin
      held <= '0;
    end else if (take) begin
      held <= '0;
    end else if (key_stb && !held.valid) begin
      held.valid <= 1'b1;
      held.multi <= key_multi;
    end
  end

  always_comb begin
    if (held.valid) begin
      req = held;
    end else begin
      req.valid = key_stb;
      req.multi = key_multi;
    end
  end

  // R10: a held request stays unchanged until it is taken
  a_r10_hold_kept: assert property (@(posedge clk) disable iff (rst)
    (held.valid && !take) |=> (held.valid && held.multi == $past(held.multi)));
endmodule

// File: rtl/step_catch.sv
module step_catch #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic step_key,
  input  logic idle,
  input  logic boundary,
  output logic step_now
);
  logic synced;
  logic prev;
  logic pend;
  logic rise;

  generate
    if (SYNC_STAGES == 0) begin : g_nosync
      assign synced = step_key;
    end else begin : g_sync
      logic [SYNC_STAGES-1:0] chain;
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[SYNC_STAGES-2 >= 0 ? SYNC_STAGES-2 : 0:0], step_key} & {SYNC_STAGES{1'b1}};
      end
      assign synced = chain[SYNC_STAGES-1];
    end
  endgenerate

  assign rise     = synced && !prev;
  assign step_now = pend || (rise && !idle);

  always_ff @(posedge clk) begin
    if (rst) begin
      prev <= 1'b0;
      pend <= 1'b0;
    end else begin
      prev <= synced;
      if (boundary)           pend <= 1'b0;
      else if (rise && !idle) pend <= 1'b1;
    end
  end

  // R8: no step is ever pending while the machine is idle
  a_r8_no_pend_idle: assert property (@(posedge clk) disable iff (rst)
    idle |-> !pend);
endmodule

// File: rtl/cycle_ctrl.sv
module cycle_ctrl
  import op_seq_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     num_end,
  input  logic     done,
  input  logic     manual,
  input  key_req_t req,
  input  logic     step_now,
  output logic     take,
  output logic     idle_nx,
  output logic     op,
  output logic     idle
);
  logic cur_multi;
  logic op_nx;
  logic multi_nx;

  always_comb begin
    idle_nx  = idle;
    op_nx    = op;
    multi_nx = cur_multi;
    take     = 1'b0;
    if (num_end) begin
      if (op && idle && cur_multi)  idle_nx = 1'b0;
      else if (op && !idle && done) idle_nx = 1'b1;
      if (!idle_nx) begin
        op_nx = manual ? step_now : 1'b1;
      end else begin
        op_nx    = req.valid;
        take     = req.valid;
        multi_nx = req.multi;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      op        <= 1'b0;
      idle      <= 1'b1;
      cur_multi <= 1'b0;
    end else begin
      op        <= op_nx;
      idle      <= idle_nx;
      cur_multi <= multi_nx;
    end
  end

  // R2: op holds steady except across a number-cycle boundary
  a_r2_op_steady: assert property (@(posedge clk) disable iff (rst)
    !num_end |=> $stable(op));
  // R5: idle moves only at the end of an OP cycle
  a_r5_idle_at_op_end: assert property (@(posedge clk) disable iff (rst)
    !(num_end && op) |=> $stable(idle));
  // R6: without done, a calculating OP cycle keeps the machine busy
  a_r6_busy_without_done: assert property (@(posedge clk) disable iff (rst)
    (num_end && op && !idle && !done) |=> !idle);
endmodule

// File: rtl/op_cycle_seq.sv
module op_cycle_seq
  import op_seq_pkg::*;
#(
  parameter int STEP_SYNC = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic num_end,
  input  logic key_stb,
  input  logic key_multi,
  input  logic done,
  input  logic manual,
  input  logic step_key,
  input  logic disp_force,
  output logic op,
  output logic idle,
  output logic disp_en
);
  key_req_t req;
  logic     take;
  logic     step_now;
  logic     idle_nx;

  key_hold u_keys (
    .clk(clk), .rst(rst), .key_stb(key_stb), .key_multi(key_multi),
    .take(take), .req(req)
  );

  step_catch #(.SYNC_STAGES(STEP_SYNC)) u_step (
    .clk(clk), .rst(rst), .step_key(step_key), .idle(idle),
    .boundary(num_end), .step_now(step_now)
  );

  cycle_ctrl u_ctrl (
    .clk(clk), .rst(rst), .num_end(num_end), .done(done), .manual(manual),
    .req(req), .step_now(step_now), .take(take), .idle_nx(idle_nx),
    .op(op), .idle(idle)
  );

  always_ff @(posedge clk) begin
    if (rst) disp_en <= 1'b1;
    else     disp_en <= idle_nx || disp_force;
  end

  // R9: display enable tracks idle or the previous force value
  a_r9_disp_follow: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (disp_en == (idle || $past(disp_force))));
endmodule

// File: tb/tb_op_cycle_seq.sv
`timescale 1ns/1ps
module tb_op_cycle_seq;
  localparam int NC = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic key_stb = 1'b0, key_multi = 1'b0, manual = 1'b0;
  logic step_key = 1'b0, disp_force = 1'b0, done_force = 1'b0;
  logic op, idle, disp_en, num_end, done;
  int cnt = 0;
  int nc_idx = 0, ops = 0, calc_ops = 0, idle_low = 0;
  int first_op_nc = -1, strobe_nc = 0, bad_boundary = 0, done_k = 0;
  int checks = 0, fails = 0;
  logic op_at0 = 1'b0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  op_cycle_seq dut (
    .clk(clk), .rst(rst), .num_end(num_end), .key_stb(key_stb),
    .key_multi(key_multi), .done(done), .manual(manual), .step_key(step_key),
    .disp_force(disp_force), .op(op), .idle(idle), .disp_en(disp_en)
  );

  assign num_end = !rst && (cnt == NC-1);
  assign done = done_force || (done_k != 0 && calc_ops >= done_k);

  always @(posedge clk) begin
    if (rst) cnt <= 0;
    else     cnt <= (cnt == NC-1) ? 0 : cnt + 1;
  end

  always @(negedge clk) begin
    if (!rst) begin
      if (cnt == 0) begin
        nc_idx++;
        op_at0 = op;
        if (op) begin
          ops++;
          if (!idle) calc_ops++;
          if (first_op_nc < 0) first_op_nc = nc_idx;
        end
        if (!idle) idle_low++;
      end else if (op !== op_at0) begin
        bad_boundary++;
      end
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_nc(input int n);
    repeat (n) begin
      do @(negedge clk); while (cnt != 1);
    end
  endtask

  task automatic clear_counts();
    ops = 0; calc_ops = 0; idle_low = 0; first_op_nc = -1;
  endtask

  task automatic fire_key(input logic multi, input int off);
    do @(negedge clk); while (cnt != off);
    key_stb = 1'b1; key_multi = multi; strobe_nc = nc_idx;
    @(negedge clk);
    key_stb = 1'b0;
  endtask

  task automatic press_step();
    do @(negedge clk); while (cnt != 2);
    step_key = 1'b1;
    repeat (12) @(negedge clk);
    step_key = 1'b0;
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      report();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(op == 1'b0 && idle == 1'b1 && disp_en == 1'b1, "R1 in reset", {op, idle, disp_en}, 3'b011);
    rst = 1'b0;
    @(negedge clk);
    check(op == 1'b0 && idle == 1'b1 && disp_en == 1'b1, "R1 after reset", {op, idle, disp_en}, 3'b011);
    wait_nc(1);

    // R4 / R3: simple key at every offset
    for (int off = 1; off < NC; off++) begin
      clear_counts();
      fire_key(1'b0, off);
      wait_nc(3);
      check(ops == 1, "R4 simple op count", ops, 1);
      check(idle_low == 0, "R4 idle kept", idle_low, 0);
      check(first_op_nc == strobe_nc + 1, "R3 start cycle", first_op_nc, strobe_nc + 1);
    end

    // R5: automatic chaining, done in the k-th calculating cycle
    for (int k = 1; k <= 4; k++) begin
      for (int j = 0; j < 3; j++) begin
        int off;
        off = 1 + 3 * j;
        clear_counts();
        done_k = k;
        fire_key(1'b1, off);
        wait_nc(k + 4);
        check(ops == 1 + k, "R5 op count", ops, 1 + k);
        check(idle_low == k, "R5 busy cycles", idle_low, k);
        check(first_op_nc == strobe_nc + 1, "R3 multi start", first_op_nc, strobe_nc + 1);
        check(idle == 1'b1, "R5 back to idle", idle, 1);
        done_k = 0;
      end
    end

    // R7: manual stepping, held key counts once
    manual = 1'b1;
    for (int k = 1; k <= 3; k++) begin
      clear_counts();
      done_k = k;
      fire_key(1'b1, 3);
      wait_nc(4);
      check(ops == 1, "R7 no auto chaining", ops, 1);
      check(idle == 1'b0, "R7 calculating", idle, 0);
      for (int i = 1; i <= k; i++) begin
        press_step();
        wait_nc(3);
        check(ops == 1 + i, "R7 one op per step", ops, 1 + i);
      end
      check(idle == 1'b1, "R7 ends idle", idle, 1);
      done_k = 0;
    end

    // R8: step while idle is discarded
    clear_counts();
    press_step();
    wait_nc(3);
    check(ops == 0, "R8 idle step ignored", ops, 0);
    check(idle_low == 0, "R8 idle kept", idle_low, 0);

    // R6: done outside an OP cycle is ignored
    clear_counts();
    fire_key(1'b1, 3);
    wait_nc(3);
    done_force = 1'b1;
    wait_nc(3);
    check(idle == 1'b0, "R6 done ignored", idle, 0);
    check(ops == 1, "R6 no extra op", ops, 1);
    press_step();
    wait_nc(3);
    check(ops == 2, "R6 stepped op", ops, 2);
    check(idle == 1'b1, "R6 done taken at op end", idle, 1);
    done_force = 1'b0;

    // R10: key during a calculation is held, second one dropped
    manual = 1'b0;
    clear_counts();
    done_k = 3;
    fire_key(1'b1, 2);
    wait_nc(2);
    fire_key(1'b0, 3);
    fire_key(1'b1, 5);
    wait_nc(8);
    check(ops == 5, "R10 held key ran once", ops, 5);
    check(idle_low == 3, "R10 busy cycles", idle_low, 3);
    check(idle == 1'b1, "R10 idle at end", idle, 1);
    done_k = 0;

    // R9: display enable and its force
    manual = 1'b1;
    clear_counts();
    fire_key(1'b1, 2);
    wait_nc(3);
    check(disp_en == 1'b0, "R9 off while busy", disp_en, 0);
    disp_force = 1'b1;
    @(negedge clk);
    check(disp_en == 1'b1, "R9 forced on", disp_en, 1);
    disp_force = 1'b0;
    @(negedge clk);
    check(disp_en == 1'b0, "R9 force released", disp_en, 0);
    done_k = 1;
    press_step();
    wait_nc(3);
    check(idle == 1'b1 && disp_en == 1'b1, "R9 on when idle", disp_en, 1);
    done_k = 0;

    check(bad_boundary == 0, "R2 op changed mid cycle", bad_boundary, 0);
    finished = 1;
    report();
  end
endmodule